// File: doc/BRIEF.md
# Paired-Page TLB Lookup Unit

This block translates a virtual address through a small, fully associative translation buffer. Each entry describes two neighbouring virtual pages that share one tag, one page-size mask and one identity tag; each of the two pages has its own physical frame base and its own attribute bits (valid, writable, no-read, no-execute). The lookup is purely combinational. It takes the address, the access kind and the current identity, and returns a result code, the physical address and a three-bit permission set.

Entries are loaded through a single synchronous write port. A write targets one entry index and replaces the whole entry on a rising clock edge. The pipeline around the block asks for a lookup, reads the result code in the same cycle, and then either uses the translation or raises the fault that the code names.

Top module: `tlbp_lookup`

## Requirements
- R1: After reset every entry is marked hardware-invalidated, so every lookup gives NOMATCH (code 1), whatever address or identity is presented.
- R2: When `wr_en` is high at a rising edge, the entry at `wr_idx` takes all the written fields, and lookups see the new contents from the next cycle on. A later write to the same index replaces the earlier contents.
- R3: An entry hits only when three things hold together. Its global flag is set or its identity tag equals the current one. Its tag equals the address in every bit above the effective mask. Its hardware-invalidate flag is clear.
- R4: With `mmid_mode` high the identity compare uses the 16-bit map ID (`cur_mmid` against each entry's map ID). With `mmid_mode` low it uses the 8-bit ASID.
- R5: The effective mask is bits [12:0] all set, with the 16-bit mask field placed at bits [28:13]. A field of all zeros gives 4 KB pages, and a field of 2'b11 gives 16 KB pages. The field is written as contiguous ones from bit 0.
- R6: The odd page of a pair is selected when the address bit at the top set bit of the effective mask is 1. For 4 KB pages that is bit 12. For a mask field of 2'b11 it is bit 14.
- R7: On a hit the checks apply in a fixed priority. A clear valid bit gives INVALID (2). A fetch to a no-execute page gives XI (4). A load to a no-read page gives RI (5). A store to a page whose write bit is clear gives DIRTY (3). Anything else gives MATCH (0). The access encoding is fetch=0, load=1 and store=2; code 3 acts as a load. An entry's attribute nibble is {valid, write, no-read, no-execute}, with bit 3 down to bit 0.
- R8: On MATCH, `phys_addr` is the selected page's frame base ORed with the address bits under the effective mask shifted right by one. `perm` is {execute, write, read}, bit 2 down to bit 0. Read is always set, write equals the page's write bit, and execute is the inverse of its no-execute bit.
- R9: With no hit the code is NOMATCH. For every code other than MATCH, `phys_addr` and `perm` are zero.
- R10: When several entries hit, the lowest index supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the write port |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | IDX_W | Entry index to write |
| wr_vpn | input | 32 | Virtual tag of the page pair |
| wr_mask | input | 16 | Page-size mask field (address bits 28:13) |
| wr_asid | input | 8 | ASID tag |
| wr_mmid | input | 16 | Map ID tag |
| wr_global | input | 1 | Match regardless of identity |
| wr_hw_inval | input | 1 | Entry never hits |
| wr_pfn_even | input | 32 | Frame base of the even page |
| wr_attr_even | input | 4 | {valid, write, no-read, no-execute} for the even page |
| wr_pfn_odd | input | 32 | Frame base of the odd page |
| wr_attr_odd | input | 4 | {valid, write, no-read, no-execute} for the odd page |
| lk_va | input | 32 | Virtual address to translate |
| lk_access | input | 2 | 0 fetch, 1 load, 2 store |
| cur_asid | input | 8 | Current ASID |
| cur_mmid | input | 16 | Current map ID |
| mmid_mode | input | 1 | Select map-ID compare |
| res_code | output | 3 | Result code |
| phys_addr | output | 32 | Translated address |
| perm | output | 3 | {execute, write, read} |

## Verification
The first entry is a plain 4 KB pair with one writable and one read-only page. Lookups with a load, a store and a foreign ASID separate even/odd selection, the DIRTY check and identity rejection. A second pair of entries is deliberately contradictory: valid clear together with no-execute set, and no-read set together with the write bit clear. Driving all three access kinds into them shows that the check order matters and that each inhibit bit applies only to its own access kind. A 16 KB entry probed at both halves and just past its end exercises the mask widening and the odd-select bit. Two entries that share a tag, one of them later disabled by an overwrite, expose the lowest-index rule and the replace-on-write behaviour.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
  parameter int ADDR_W    = 32;
  parameter int MASK_W    = 16;
  parameter int ASID_W    = 8;
  parameter int MMID_W    = 16;
  parameter int MIN_SHIFT = 13;  // bits always inside the mask: two 4 KB pages
  localparam int TOP_PAD  = ADDR_W - MASK_W - MIN_SHIFT;

  typedef enum logic [2:0] {
    RES_MATCH   = 3'd0,
    RES_NOMATCH = 3'd1,
    RES_INVALID = 3'd2,
    RES_DIRTY   = 3'd3,
    RES_XI      = 3'd4,
    RES_RI      = 3'd5
  } res_e;

  typedef enum logic [1:0] {
    ACC_FETCH = 2'd0,
    ACC_LOAD  = 2'd1,
    ACC_STORE = 2'd2
  } acc_e;

  typedef struct packed {
    logic [ADDR_W-1:0] pfn;
    logic              v;
    logic              d;
    logic              ri;
    logic              xi;
  } half_t;

  typedef struct packed {
    logic [ADDR_W-1:0] vpn;
    logic [MASK_W-1:0] mask;
    logic [ASID_W-1:0] asid;
    logic [MMID_W-1:0] mmid;
    logic              g;
    logic              ehinv;
    half_t             even;
    half_t             odd;
  } entry_t;

  function automatic entry_t blank_entry();
    entry_t e;
    e       = '0;
    e.ehinv = 1'b1;
    return e;
  endfunction

  // Mask field widened with the offset bits of a 4 KB page pair.
  function automatic logic [ADDR_W-1:0] eff_mask(input logic [MASK_W-1:0] m);
    return {{TOP_PAD{1'b0}}, m, {MIN_SHIFT{1'b1}}};
  endfunction

  // Odd half: address bit at the top set bit of the effective mask.
  function automatic logic odd_half(input logic [ADDR_W-1:0] va,
                                    input logic [ADDR_W-1:0] em);
    return |(va & em & ~(em >> 1));
  endfunction

  function automatic logic [ADDR_W-1:0] phys(input logic [ADDR_W-1:0] pfn,
                                             input logic [ADDR_W-1:0] va,
                                             input logic [ADDR_W-1:0] em);
    return pfn | (va & (em >> 1));
  endfunction
endpackage

// File: rtl/tlbp_entry_store.sv
module tlbp_entry_store
  import tlbp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  entry_t           wr_entry,
  output entry_t           ents [NUM_ENTRIES]
);
  entry_t ents_q [NUM_ENTRIES];

  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_ent
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                               ents_q[k] <= blank_entry();
      else if (wr_en && wr_idx == IDX_W'(k))    ents_q[k] <= wr_entry;
    end
    assign ents[k] = ents_q[k];
  end

  // R2: a write is visible in the addressed entry one edge later
  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ents_q[$past(wr_idx)] == $past(wr_entry)));
endmodule

// File: rtl/tlbp_hit_vec.sv
module tlbp_hit_vec
  import tlbp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16
) (
  input  entry_t                  ents [NUM_ENTRIES],
  input  logic [ADDR_W-1:0]       va,
  input  logic [ASID_W-1:0]       cur_asid,
  input  logic [MMID_W-1:0]       cur_mmid,
  input  logic                    mmid_mode,
  output logic [NUM_ENTRIES-1:0]  hit
);
  for (genvar k = 0; k < NUM_ENTRIES; k++) begin : g_cmp
    logic [ADDR_W-1:0] em;
    logic              id_eq;
    logic              tag_eq;
    assign em     = eff_mask(ents[k].mask);
    assign id_eq  = mmid_mode ? (ents[k].mmid == cur_mmid) : (ents[k].asid == cur_asid);
    assign tag_eq = ((ents[k].vpn ^ va) & ~em) == '0;
    assign hit[k] = (ents[k].g | id_eq) & tag_eq & ~ents[k].ehinv;
  end
endmodule

// File: rtl/tlbp_resolve.sv
module tlbp_resolve
  import tlbp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  entry_t                 ents [NUM_ENTRIES],
  input  logic [NUM_ENTRIES-1:0] hit,
  input  logic [ADDR_W-1:0]      va,
  input  logic [1:0]             access,
  output res_e                   res,
  output logic [ADDR_W-1:0]      pa,
  output logic [2:0]             perm
);
  logic [IDX_W-1:0]  sel;
  logic              any_hit;
  entry_t            e;
  logic [ADDR_W-1:0] em;
  logic              odd;
  half_t             h;
  logic              is_fetch, is_store, is_load;

  // lowest index wins: scan downward so the last assignment is the lowest hit
  always_comb begin
    sel     = '0;
    any_hit = 1'b0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (hit[i]) begin
        sel     = IDX_W'(i);
        any_hit = 1'b1;
      end
    end
  end

  assign e        = ents[sel];
  assign em       = eff_mask(e.mask);
  assign odd      = odd_half(va, em);
  assign h        = odd ? e.odd : e.even;
  assign is_fetch = (access == ACC_FETCH);
  assign is_store = (access == ACC_STORE);
  assign is_load  = !is_fetch && !is_store;

  always_comb begin
    if (!any_hit)                res = RES_NOMATCH;
    else if (!h.v)               res = RES_INVALID;
    else if (is_fetch && h.xi)   res = RES_XI;
    else if (is_load && h.ri)    res = RES_RI;
    else if (is_store && !h.d)   res = RES_DIRTY;
    else                         res = RES_MATCH;
  end

  assign pa   = (res == RES_MATCH) ? phys(h.pfn, va, em) : '0;
  assign perm = (res == RES_MATCH) ? {~h.xi, h.d, 1'b1} : 3'b000;

  // R9: no hitting entry means NOMATCH
  p_nohit_nomatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit == '0) |-> (res == RES_NOMATCH));
  // R8: a store that translates must carry write permission
  p_store_writable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res == RES_MATCH && access == 2'd2) |-> perm[1]);
  // R8: a fetch that translates must carry execute permission
  p_fetch_exec_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (res == RES_MATCH && access == 2'd0) |-> perm[2]);
endmodule

// File: rtl/tlbp_lookup.sv
module tlbp_lookup
  import tlbp_pkg::*;
#(
  parameter int NUM_ENTRIES = 16,
  localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [31:0]      wr_vpn,
  input  logic [15:0]      wr_mask,
  input  logic [7:0]       wr_asid,
  input  logic [15:0]      wr_mmid,
  input  logic             wr_global,
  input  logic             wr_hw_inval,
  input  logic [31:0]      wr_pfn_even,
  input  logic [3:0]       wr_attr_even,
  input  logic [31:0]      wr_pfn_odd,
  input  logic [3:0]       wr_attr_odd,
  input  logic [31:0]      lk_va,
  input  logic [1:0]       lk_access,
  input  logic [7:0]       cur_asid,
  input  logic [15:0]      cur_mmid,
  input  logic             mmid_mode,
  output logic [2:0]       res_code,
  output logic [31:0]      phys_addr,
  output logic [2:0]       perm
);
  initial begin
    a_entry_count: assert (NUM_ENTRIES >= 1 && NUM_ENTRIES <= 64);
  end

  entry_t                 wr_entry;
  entry_t                 ents [NUM_ENTRIES];
  logic [NUM_ENTRIES-1:0] hit;
  res_e                   res;

  always_comb begin
    wr_entry          = '0;
    wr_entry.vpn      = wr_vpn;
    wr_entry.mask     = wr_mask;
    wr_entry.asid     = wr_asid;
    wr_entry.mmid     = wr_mmid;
    wr_entry.g        = wr_global;
    wr_entry.ehinv    = wr_hw_inval;
    wr_entry.even.pfn = wr_pfn_even;
    wr_entry.even.v   = wr_attr_even[3];
    wr_entry.even.d   = wr_attr_even[2];
    wr_entry.even.ri  = wr_attr_even[1];
    wr_entry.even.xi  = wr_attr_even[0];
    wr_entry.odd.pfn  = wr_pfn_odd;
    wr_entry.odd.v    = wr_attr_odd[3];
    wr_entry.odd.d    = wr_attr_odd[2];
    wr_entry.odd.ri   = wr_attr_odd[1];
    wr_entry.odd.xi   = wr_attr_odd[0];
  end

  tlbp_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_entry(wr_entry), .ents(ents));

  tlbp_hit_vec #(.NUM_ENTRIES(NUM_ENTRIES)) u_hit (
    .ents(ents), .va(lk_va), .cur_asid(cur_asid), .cur_mmid(cur_mmid),
    .mmid_mode(mmid_mode), .hit(hit));

  tlbp_resolve #(.NUM_ENTRIES(NUM_ENTRIES)) u_res (
    .clk(clk), .rst_n(rst_n), .ents(ents), .hit(hit), .va(lk_va),
    .access(lk_access), .res(res), .pa(phys_addr), .perm(perm));

  assign res_code = res;

  // R9: outputs stay quiet unless the translation succeeds
  p_quiet_nonmatch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (res_code != 3'd0) |-> (phys_addr == '0 && perm == 3'b000));
endmodule

// File: tb/tlbp_lookup_tb_top.sv
module tlbp_lookup_tb_top;
  localparam int N = 16;
  localparam int IW = $clog2(N);

  logic clk = 1'b0, rst_n = 1'b0;
  logic wr_en = 1'b0; logic [IW-1:0] wr_idx = '0;
  logic [31:0] wr_vpn = '0, wr_pfn_even = '0, wr_pfn_odd = '0, lk_va = '0;
  logic [15:0] wr_mask = '0, wr_mmid = '0, cur_mmid = '0;
  logic [7:0]  wr_asid = '0, cur_asid = '0;
  logic wr_global = 1'b0, wr_hw_inval = 1'b0, mmid_mode = 1'b0;
  logic [3:0] wr_attr_even = '0, wr_attr_odd = '0;
  logic [1:0] lk_access = '0;
  logic [2:0] res_code, perm;
  logic [31:0] phys_addr;

  tlbp_lookup #(.NUM_ENTRIES(N)) dut_i (.*);

  always #4 clk = ~clk;

  // bench model of the entry contents
  logic [31:0] m_vpn [N], m_pe [N], m_po [N];
  logic [15:0] m_mask [N], m_mmid [N];
  logic [7:0]  m_asid [N];
  logic        m_g [N], m_inv [N];
  logic [3:0]  m_ae [N], m_ao [N];

  typedef struct { logic [2:0] res; logic [31:0] pa; logic [2:0] perm; string tag; } exp_t;
  exp_t sbq [$];
  event go;
  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  function automatic exp_t predict(logic [31:0] va, logic [1:0] acc,
                                   logic [7:0] ca, logic [15:0] cm, logic mm);
    exp_t r; bit found = 0; int w = 0;
    r.res = 3'd1; r.pa = '0; r.perm = '0;
    for (int i = 0; i < N; i++) begin
      logic [31:0] full; logic idok;
      full = {3'b000, m_mask[i], 13'h1fff};
      idok = m_g[i] || (mm ? (m_mmid[i] == cm) : (m_asid[i] == ca));
      if (!found && !m_inv[i] && idok && (((va ^ m_vpn[i]) & ~full) == 0)) begin
        found = 1; w = i;
      end
    end
    if (found) begin
      logic [31:0] full, top, base; logic [3:0] at;
      full = {3'b000, m_mask[w], 13'h1fff};
      top  = (full + 32'd1) >> 1;
      at   = ((va & top) != 0) ? m_ao[w] : m_ae[w];
      base = ((va & top) != 0) ? m_po[w] : m_pe[w];
      if (!at[3])                          r.res = 3'd2;
      else if (acc == 2'd0 && at[0])       r.res = 3'd4;
      else if ((acc == 2'd1 || acc == 2'd3) && at[1]) r.res = 3'd5;
      else if (acc == 2'd2 && !at[2])      r.res = 3'd3;
      else begin
        r.res  = 3'd0;
        r.pa   = base | (va & (top - 32'd1));
        r.perm = {~at[0], at[2], 1'b1};
      end
    end
    return r;
  endfunction

  task automatic wr_ent(int idx, logic [31:0] vpn, logic [15:0] mask, logic [7:0] asid,
                        logic [15:0] mmid, logic g, logic inv,
                        logic [31:0] pe, logic [3:0] ae, logic [31:0] po, logic [3:0] ao);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = IW'(idx); wr_vpn = vpn; wr_mask = mask; wr_asid = asid;
    wr_mmid = mmid; wr_global = g; wr_hw_inval = inv;
    wr_pfn_even = pe; wr_attr_even = ae; wr_pfn_odd = po; wr_attr_odd = ao;
    m_vpn[idx] = vpn; m_mask[idx] = mask; m_asid[idx] = asid; m_mmid[idx] = mmid;
    m_g[idx] = g; m_inv[idx] = inv; m_pe[idx] = pe; m_ae[idx] = ae;
    m_po[idx] = po; m_ao[idx] = ao;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic look(logic [31:0] va, logic [1:0] acc, logic [7:0] ca,
                      logic [15:0] cm, logic mm, string tag);
    exp_t e;
    @(negedge clk);
    lk_va = va; lk_access = acc; cur_asid = ca; cur_mmid = cm; mmid_mode = mm;
    e = predict(va, acc, ca, cm, mm); e.tag = tag;
    sbq.push_back(e);
    -> go;
  endtask

  // monitor: pops the oldest expectation and compares it with the ports
  initial forever begin
    exp_t e;
    @(go); #2;
    e = sbq.pop_front();
    n_cmp++;
    if (res_code !== e.res || phys_addr !== e.pa || perm !== e.perm) begin
      n_bad++;
      $display("FAIL %s: got res=%0d pa=%h perm=%b, expected res=%0d pa=%h perm=%b",
               e.tag, res_code, phys_addr, perm, e.res, e.pa, e.perm);
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < N; i++) begin
      m_vpn[i] = '0; m_pe[i] = '0; m_po[i] = '0; m_mask[i] = '0; m_mmid[i] = '0;
      m_asid[i] = '0; m_g[i] = 0; m_inv[i] = 1; m_ae[i] = '0; m_ao[i] = '0;
    end
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    // R1: everything invalidated after reset
    look(32'h0000_0000, 2'd1, 8'd0, 16'd0, 1'b0, "R1 reset va0");
    look(32'h0040_0000, 2'd0, 8'd5, 16'd0, 1'b1, "R1 reset va400000");

    wr_ent(0, 32'h0040_0000, 16'h0000, 8'd5, 16'h1234, 0, 0,
           32'h1000_0000, 4'b1100, 32'h2000_0000, 4'b1000);
    look(32'h0040_0ABC, 2'd1, 8'd5, 16'd0, 1'b0, "R2 R8 even load");
    look(32'h0040_1ABC, 2'd1, 8'd5, 16'd0, 1'b0, "R6 odd load read-only");
    look(32'h0040_1000, 2'd2, 8'd5, 16'd0, 1'b0, "R7 odd store dirty");
    look(32'h0040_0010, 2'd2, 8'd5, 16'd0, 1'b0, "R8 even store");
    look(32'h0040_0ABC, 2'd1, 8'd6, 16'd0, 1'b0, "R3 foreign asid");
    look(32'h0040_0ABC, 2'd1, 8'd9, 16'h1234, 1'b1, "R4 mmid match");
    look(32'h0040_0ABC, 2'd1, 8'd5, 16'h1235, 1'b1, "R4 mmid mismatch");

    wr_ent(1, 32'h0080_0000, 16'h0000, 8'd0, 16'd0, 1, 0,
           32'h0A00_0000, 4'b1101, 32'h0B00_0000, 4'b1100);
    look(32'h0080_0F00, 2'd1, 8'd77, 16'd0, 1'b0, "R3 global load");
    look(32'h0080_0F00, 2'd0, 8'd77, 16'd0, 1'b0, "R7 fetch xi");

    wr_ent(2, 32'h00C0_0000, 16'h0000, 8'd5, 16'd0, 0, 0,
           32'h0C00_0000, 4'b0001, 32'h0D00_0000, 4'b1010);
    look(32'h00C0_0004, 2'd0, 8'd5, 16'd0, 1'b0, "R7 invalid before xi");
    look(32'h00C0_1004, 2'd1, 8'd5, 16'd0, 1'b0, "R7 load ri");
    look(32'h00C0_1004, 2'd3, 8'd5, 16'd0, 1'b0, "R7 code3 as load");
    look(32'h00C0_1004, 2'd2, 8'd5, 16'd0, 1'b0, "R7 store ignores ri");
    look(32'h00C0_1004, 2'd0, 8'd5, 16'd0, 1'b0, "R7 fetch ignores ri");

    wr_ent(3, 32'h0100_0000, 16'h0000, 8'd5, 16'd0, 1, 1,
           32'h0E00_0000, 4'b1100, 32'h0F00_0000, 4'b1100);
    look(32'h0100_0000, 2'd1, 8'd5, 16'd0, 1'b0, "R3 hw invalidated");

    wr_ent(4, 32'h0200_0000, 16'h0003, 8'd5, 16'd0, 0, 0,
           32'h3000_0000, 4'b1100, 32'h4000_0000, 4'b1100);
    look(32'h0200_3FFC, 2'd1, 8'd5, 16'd0, 1'b0, "R5 16K even");
    look(32'h0200_7004, 2'd1, 8'd5, 16'd0, 1'b0, "R6 16K odd");
    look(32'h0200_8000, 2'd1, 8'd5, 16'd0, 1'b0, "R5 past 32K pair");

    wr_ent(7, 32'h0300_0000, 16'h0000, 8'd0, 16'd0, 1, 0,
           32'h7000_0000, 4'b1100, 32'h7100_0000, 4'b1100);
    wr_ent(5, 32'h0300_0000, 16'h0000, 8'd0, 16'd0, 1, 0,
           32'h5000_0000, 4'b1100, 32'h5100_0000, 4'b1100);
    look(32'h0300_0123, 2'd1, 8'd3, 16'd0, 1'b0, "R10 lowest index");
    wr_ent(5, 32'h0300_0000, 16'h0000, 8'd0, 16'd0, 1, 1,
           32'h5000_0000, 4'b1100, 32'h5100_0000, 4'b1100);
    look(32'h0300_0123, 2'd1, 8'd3, 16'd0, 1'b0, "R2 overwrite R10");

    wr_ent(N - 1, 32'h0400_0000, 16'h0000, 8'd5, 16'd0, 0, 0,
           32'h6000_0000, 4'b1100, 32'h6100_0000, 4'b1100);
    look(32'h0400_1008, 2'd2, 8'd5, 16'd0, 1'b0, "R2 last index");

    repeat (3) @(posedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule